// File: doc/BRIEF.md
# Serial Loader Command Front-End

This block runs the opening handshake of a serial RAM-load session. It sits between a byte-wide UART and a downstream hex-record parser. Each received byte arrives as a one-cycle strobe with its data, together with a receive-error flag. The block answers through a transmit request that waits for the transmitter's ready handshake.

The session starts with a four-byte synchronisation preamble, and each of those bytes is echoed back unchanged. The fifth byte is the command. If it selects RAM-load, the block echoes it and, once the transmitter has taken that echo, hands control to the record parser with a single-cycle pulse. Any other command value makes the block send an error code three times and then lock up. A receive error during the header, or a byte that arrives while a reply is still waiting, also locks the block. Only reset clears that halted state.

Top module: `serial_loader_front`

## Requirements
- R1: While reset is asserted and right after it is released, tx_valid, load_go and halted are all 0.
- R2: Received bytes one to four are each transmitted back unchanged, in the order they arrived.
- R3: When the fifth received byte is 0x60, the next transmitted byte is 0x60.
- R4: load_go is high for exactly one cycle. That cycle is the one right after the edge at which the 0x60 echo is accepted (tx_valid and tx_ready both high). After that the block transmits nothing, and received bytes and rx_err neither cause a transmission nor set halted.
- R5: When the fifth received byte is any value other than 0x60, the block transmits 0x63 three times. halted goes high at the edge at which the third 0x63 is accepted.
- R6: Once halted is high, it stays high until reset. tx_valid and load_go stay 0, and received bytes and rx_err cause no transmission.
- R7: rx_err high at an edge before the handoff sets halted at that edge and drops any reply that is waiting.
- R8: While tx_valid is high and tx_ready is low, tx_valid stays high and tx_data stays stable, unless a byte or an rx_err arrives.
- R9: A byte that arrives before the handoff while a reply is waiting and not accepted in that cycle sets halted and drops the reply. A byte that arrives in the same cycle as the acceptance is handled normally.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_valid | input | 1 | One-cycle strobe: a received byte is present |
| rx_data | input | 8 | Received byte |
| rx_err | input | 1 | The UART reports a receive error |
| tx_ready | input | 1 | The transmitter accepts tx_data this cycle |
| tx_valid | output | 1 | A byte is waiting to be sent |
| tx_data | output | 8 | Byte to be sent |
| load_go | output | 1 | Single-cycle handoff pulse to the record parser |
| halted | output | 1 | The block is locked until reset |

## Verification
Two events can fall in the same cycle: a new received byte and the transmitter's acceptance of the reply still waiting. The bench provokes this by holding tx_ready low after a preamble byte, then raising tx_ready in exactly the cycle that carries the next byte. It judges the result by requiring both bytes to be echoed in order, with halted still low. The contrasting case sends the second byte while tx_ready stays low, and that case must halt with nothing transmitted.

// File: rtl/sld_pkg.sv
package sld_pkg;

  typedef enum logic [2:0] {
    S_HDR  = 3'd0,  // collecting preamble and command
    S_ECHO = 3'd1,  // command echo waiting for the transmitter
    S_ERR  = 3'd2,  // repeating the error code
    S_RUN  = 3'd3,  // control handed to the record parser
    S_HALT = 3'd4   // locked until reset
  } sld_state_e;

endpackage

// File: rtl/sld_byte_count.sv
module sld_byte_count #(
  parameter int LIMIT = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic inc,
  output logic at_limit
);
  localparam int CW = $clog2(LIMIT + 1);
  localparam logic [CW-1:0] LIM = CW'(LIMIT);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  assign at_limit = (cnt_q == LIM);
  assign cnt_en   = inc && !at_limit;

  always_comb begin
    cnt_d = cnt_q;
    if (cnt_en) cnt_d = cnt_q + CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end
endmodule

// File: rtl/sld_cmd_match.sv
module sld_cmd_match #(
  parameter int                 DATA_W   = 8,
  parameter logic [DATA_W-1:0]  CMD_LOAD = 'h60
) (
  input  logic [DATA_W-1:0] byte_i,
  output logic              hit
);
  logic [DATA_W-1:0] diff;

  for (genvar i = 0; i < DATA_W; i++) begin : g_bit
    assign diff[i] = byte_i[i] ^ CMD_LOAD[i];
  end

  assign hit = ~|diff;
endmodule

// File: rtl/sld_tx_slot.sv
module sld_tx_slot #(
  parameter int DATA_W = 8,
  parameter int REP_W  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [DATA_W-1:0] load_data,
  input  logic [REP_W-1:0]  load_reps,
  input  logic              flush,
  input  logic              tx_ready,
  output logic              tx_valid,
  output logic [DATA_W-1:0] tx_data,
  output logic              fire,
  output logic              last_fire
);
  logic              vld_q, vld_d;
  logic [DATA_W-1:0] dat_q, dat_d;
  logic [REP_W-1:0]  rem_q, rem_d;
  logic              upd_en;

  assign fire      = vld_q && tx_ready;
  assign last_fire = fire && (rem_q == REP_W'(1));
  assign tx_valid  = vld_q;
  assign tx_data   = dat_q;
  assign upd_en    = flush || load || fire;

  always_comb begin
    vld_d = vld_q;
    dat_d = dat_q;
    rem_d = rem_q;
    if (flush) begin
      vld_d = 1'b0;
      rem_d = '0;
    end else if (load) begin
      vld_d = 1'b1;
      dat_d = load_data;
      rem_d = load_reps;
    end else if (fire) begin
      rem_d = rem_q - REP_W'(1);
      if (rem_q == REP_W'(1)) vld_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
      dat_q <= '0;
      rem_q <= '0;
    end else if (upd_en) begin
      vld_q <= vld_d;
      dat_q <= dat_d;
      rem_q <= rem_d;
    end
  end
endmodule

// File: rtl/serial_loader_front.sv
module serial_loader_front #(
  parameter int                DATA_W       = 8,
  parameter int                PREAMBLE_LEN = 4,
  parameter logic [DATA_W-1:0] CMD_LOAD     = 'h60,
  parameter logic [DATA_W-1:0] ERR_CODE     = 'h63,
  parameter int                ERR_REPEAT   = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_valid,
  input  logic [DATA_W-1:0] rx_data,
  input  logic              rx_err,
  input  logic              tx_ready,
  output logic              tx_valid,
  output logic [DATA_W-1:0] tx_data,
  output logic              load_go,
  output logic              halted
);
  import sld_pkg::*;

  localparam int REP_W = $clog2(ERR_REPEAT + 1);

  sld_state_e        state_q, state_d;
  logic              go_q, go_d;
  logic              run_q;
  logic              at_cmd, cmd_hit;
  logic              cnt_inc;
  logic              slot_load, slot_flush;
  logic [DATA_W-1:0] slot_data;
  logic [REP_W-1:0]  slot_reps;
  logic              fire, last_fire;
  logic              overrun;

  sld_byte_count #(.LIMIT(PREAMBLE_LEN)) u_count (
    .clk      (clk),
    .rst_n    (rst_n),
    .inc      (cnt_inc),
    .at_limit (at_cmd)
  );

  sld_cmd_match #(.DATA_W(DATA_W), .CMD_LOAD(CMD_LOAD)) u_match (
    .byte_i (rx_data),
    .hit    (cmd_hit)
  );

  sld_tx_slot #(.DATA_W(DATA_W), .REP_W(REP_W)) u_slot (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (slot_load),
    .load_data (slot_data),
    .load_reps (slot_reps),
    .flush     (slot_flush),
    .tx_ready  (tx_ready),
    .tx_valid  (tx_valid),
    .tx_data   (tx_data),
    .fire      (fire),
    .last_fire (last_fire)
  );

  // a byte lands while the waiting reply is not taken this cycle
  assign overrun = rx_valid && tx_valid && !fire;

  always_comb begin
    state_d    = state_q;
    go_d       = 1'b0;
    cnt_inc    = 1'b0;
    slot_load  = 1'b0;
    slot_flush = 1'b0;
    slot_data  = rx_data;
    slot_reps  = REP_W'(1);
    unique case (state_q)
      S_HDR: begin
        if (rx_err || overrun) begin
          state_d    = S_HALT;
          slot_flush = 1'b1;
        end else if (rx_valid) begin
          slot_load = 1'b1;
          if (!at_cmd) begin
            cnt_inc = 1'b1;
          end else if (cmd_hit) begin
            slot_data = CMD_LOAD;
            state_d   = S_ECHO;
          end else begin
            slot_data = ERR_CODE;
            slot_reps = REP_W'(ERR_REPEAT);
            state_d   = S_ERR;
          end
        end
      end
      S_ECHO: begin
        if (rx_err) begin
          state_d    = S_HALT;
          slot_flush = 1'b1;
        end else if (fire) begin
          state_d = S_RUN;
          go_d    = 1'b1;
        end else if (rx_valid) begin
          state_d    = S_HALT;
          slot_flush = 1'b1;
        end
      end
      S_ERR: begin
        if (rx_err || overrun) begin
          state_d    = S_HALT;
          slot_flush = 1'b1;
        end else if (last_fire) begin
          state_d = S_HALT;
        end
      end
      S_RUN:   state_d = S_RUN;
      S_HALT:  state_d = S_HALT;
      default: begin
        state_d    = S_HALT;
        slot_flush = 1'b1;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_HDR;
      go_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      go_q    <= go_d;
    end
  end

  assign run_q   = (state_q == S_RUN);
  assign load_go = go_q;
  assign halted  = (state_q == S_HALT);
endmodule

// File: rtl/sld_checker.sv
module sld_checker #(
  parameter int                DATA_W   = 8,
  parameter logic [DATA_W-1:0] CMD_LOAD = 'h60
) (
  input logic              clk,
  input logic              rst_n,
  input logic              rx_valid,
  input logic              rx_err,
  input logic              tx_ready,
  input logic              tx_valid,
  input logic [DATA_W-1:0] tx_data,
  input logic              load_go,
  input logic              halted,
  input logic              in_run
);

  a_r4_go_after_echo: assert property (@(posedge clk) disable iff (!rst_n)
    load_go |-> $past(tx_valid && tx_ready && (tx_data == CMD_LOAD)));

  a_r4_go_single: assert property (@(posedge clk) disable iff (!rst_n)
    load_go |=> !load_go);

  a_r4_run_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    in_run |-> !tx_valid && !halted);

  a_r6_halt_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    halted |=> halted);

  a_r6_halt_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    halted |-> !tx_valid && !load_go);

  a_r7_err_halts: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_err && !in_run && !load_go) |=> halted && !tx_valid);

  a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready && !rx_err && !rx_valid) |=> tx_valid && $stable(tx_data));

  a_r9_overrun: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready && rx_valid && !in_run) |=> halted);

endmodule

bind serial_loader_front sld_checker #(
  .DATA_W   (DATA_W),
  .CMD_LOAD (CMD_LOAD)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .rx_valid (rx_valid),
  .rx_err   (rx_err),
  .tx_ready (tx_ready),
  .tx_valid (tx_valid),
  .tx_data  (tx_data),
  .load_go  (load_go),
  .halted   (halted),
  .in_run   (run_q)
);

// File: tb/tb_serial_loader_front.sv
module tb_serial_loader_front;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       rx_valid, rx_err, tx_ready;
  logic [7:0] rx_data;
  logic       tx_valid, load_go, halted;
  logic [7:0] tx_data;

  int tests = 0;
  int fails = 0;
  int ready_mode = 0;     // 0: always ready, 1: toggling, 2: manual
  logic [7:0] txlog [0:31];
  int txn = 0;
  int go_cnt = 0;

  serial_loader_front dut (
    .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_data(rx_data),
    .rx_err(rx_err), .tx_ready(tx_ready), .tx_valid(tx_valid),
    .tx_data(tx_data), .load_go(load_go), .halted(halted)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    #1;
    if (ready_mode == 0)      tx_ready = 1'b1;
    else if (ready_mode == 1) tx_ready = ~tx_ready;
  end

  always @(negedge clk) begin
    if (rst_n) begin
      if (tx_valid && tx_ready && txn < 32) begin
        txlog[txn] = tx_data;
        txn++;
      end
      if (load_go) go_cnt++;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #2;
  endtask

  task automatic do_reset();
    rst_n = 1'b0; rx_valid = 1'b0; rx_err = 1'b0; rx_data = 8'h00;
    repeat (3) tick();
    check(!tx_valid && !load_go && !halted, "R1 in reset", {tx_valid, load_go, halted}, 0);
    rst_n = 1'b1;
    tick();
    txn = 0; go_cnt = 0;
    check(!tx_valid && !load_go && !halted, "R1 after release", {tx_valid, load_go, halted}, 0);
  endtask

  task automatic put(input logic [7:0] b);
    rx_valid = 1'b1; rx_data = b;
    tick();
    rx_valid = 1'b0;
  endtask

  task automatic pulse_err();
    rx_err = 1'b1;
    tick();
    rx_err = 1'b0;
  endtask

  task automatic drain();
    for (int i = 0; i < 20 && tx_valid; i++) tick();
  endtask

  task automatic t_good(input int mode, input string tag);
    logic [7:0] pre [4] = '{8'hA5, 8'h5A, 8'h00, 8'hFF};
    ready_mode = mode;
    do_reset();
    for (int i = 0; i < 4; i++) begin put(pre[i]); drain(); end
    put(8'h60); drain();
    repeat (3) tick();
    check(txn == 5, {"R2 R3 count ", tag}, txn, 5);
    for (int i = 0; i < 4; i++)
      check(txlog[i] == pre[i], {"R2 echo ", tag}, txlog[i], pre[i]);
    check(txlog[4] == 8'h60, {"R3 cmd echo ", tag}, txlog[4], 8'h60);
    check(go_cnt == 1, {"R4 single pulse ", tag}, go_cnt, 1);
    put(8'h3A); pulse_err(); put(8'h60);
    repeat (3) tick();
    check(txn == 5 && !tx_valid, {"R4 rx ignored after handoff ", tag}, txn, 5);
    check(!halted, {"R4 no halt after handoff ", tag}, halted, 0);
  endtask

  task automatic t_bad();
    ready_mode = 0;
    do_reset();
    for (int i = 0; i < 4; i++) begin put(8'h10 + 8'(i)); drain(); end
    put(8'h55);
    tick();
    tick();
    check(!halted, "R5 not halted before third", halted, 0);
    tick();
    check(halted, "R5 halted on third accept", halted, 1);
    check(txn == 7, "R5 reply count", txn, 7);
    for (int i = 4; i < 7; i++)
      check(txlog[i] == 8'h63, "R5 error code", txlog[i], 8'h63);
    check(go_cnt == 0, "R5 no handoff", go_cnt, 0);
    put(8'h60); pulse_err(); put(8'h11);
    repeat (3) tick();
    check(txn == 7 && !tx_valid && halted, "R6 halted ignores traffic", txn, 7);
  endtask

  task automatic t_rxerr();
    ready_mode = 0;
    do_reset();
    put(8'h21); drain(); put(8'h22); drain();
    pulse_err();
    check(halted && !tx_valid, "R7 rx_err halts", halted, 1);
    put(8'h23); put(8'h60);
    repeat (2) tick();
    check(txn == 2 && halted, "R6 no tx after halt", txn, 2);
  endtask

  task automatic t_rxerr_pending();
    ready_mode = 2; tx_ready = 1'b0;
    do_reset();
    put(8'h31);
    tick();
    check(tx_valid && tx_data == 8'h31, "R8 held while not ready", tx_data, 8'h31);
    pulse_err();
    check(halted && !tx_valid, "R7 pending reply dropped", tx_valid, 0);
    tx_ready = 1'b1;
    repeat (2) tick();
    check(txn == 0, "R7 nothing sent", txn, 0);
  endtask

  task automatic t_overrun();
    ready_mode = 2; tx_ready = 1'b0;
    do_reset();
    put(8'h41);
    put(8'h42);
    check(halted && !tx_valid, "R9 overrun halts", halted, 1);
    tx_ready = 1'b1;
    repeat (2) tick();
    check(txn == 0, "R9 overrun sends nothing", txn, 0);
  endtask

  task automatic t_collision();
    ready_mode = 2; tx_ready = 1'b0;
    do_reset();
    put(8'h51);
    tick();
    tx_ready = 1'b1;
    put(8'h52);
    drain();
    tick();
    check(!halted, "R9 same-cycle byte accepted", halted, 0);
    check(txn == 2, "R9 both echoed", txn, 2);
    check(txlog[0] == 8'h51 && txlog[1] == 8'h52, "R9 echo order",
          {txlog[0], txlog[1]}, 16'h5152);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    fails++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    tx_ready = 1'b1;
    t_good(0, "ready");
    t_good(1, "stalled");
    t_bad();
    t_rxerr();
    t_rxerr_pending();
    t_overrun();
    t_collision();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule